// File: doc/BRIEF.md
# Anchored Exact Floating-Point Accumulator

This block adds a stream of IEEE binary64 values into a wide fixed-point sum without rounding. The sum is held as four 64-bit two's-complement lanes. Lane i covers a 56-bit payload field whose lowest bit has weight 2^(anchor+56*i). Its upper 8 bits are headroom that absorbs carries, so the lanes overlap their neighbours by 8 bits. The anchor is a signed configuration input that gives the weight of the lowest accumulator bit. With an anchor of -76 the lanes start at 2^-76, 2^-20, 2^36 and 2^92, and the top bit of lane 3 has weight 2^155.

Each accepted value passes through a convert stage and then an add stage. The convert stage aligns the significand to the anchor and cuts it into the four payload fields. Each field is zero-extended to 64 bits. For a negative value, each lane word is also negated. The add stage adds each lane word into its running lane with no carry between lanes. Every lane sum is an integer sum modulo 2^64, so the final lane contents do not depend on the order of the inputs. Folding the overlaps back into a normal number is left to the host. The block only reports conditions the host must handle, through sticky flags.

Top module: `fpacc_anchor_top`

## Requirements
- R1: After reset, and on the clock edge where `clear` is high, all lanes become zero and all four flags go low. A value in the convert stage at that edge is discarded.
- R2: A finite value with sign s, significand m and lowest significand bit weight 2^q adds, to lane i, bits [56i+55:56i] of the 224-bit field `m << (q-anchor)`, zero-extended to 64 bits. Lane i sits at bits [64i+63:64i] of `accLanes`.
- R3: For a negative value, each lane word is negated in two's complement (0 minus the word) before it is added.
- R4: `inReady` is high in every cycle without `clear`, and one value is taken per cycle. A value accepted at clock edge k appears in `accLanes` after edge k+1, so n back-to-back values are complete n+1 edges after the first.
- R5: Feeding the same set of values in reverse order from a cleared state gives identical lane contents.
- R6: Significand bits whose weight is below 2^anchor are dropped, and the rest of the value is still added. If any dropped bit is 1, `flagInexact` is set and stays set until clear.
- R7: If a significand bit of 1 would land at weight 2^(anchor+224) or above, `flagRange` is set and the value is not added.
- R8: Zero and negative zero leave the lanes unchanged. A subnormal value (exponent field 0) uses significand {0,fraction} with lowest bit weight 2^-1074. A normal value uses {1,fraction} with lowest bit weight 2^(exponent-1075).
- R9: An exponent field of all ones (infinity or NaN) sets `flagInvalid` and leaves the lanes unchanged.
- R10: If adding a lane word to a lane gives a signed 64-bit overflow, `flagLaneOvf` is set and stays set until clear. The lane keeps the low 64 bits of the sum.
- R11: `cfgAnchor` is a signed 12-bit weight. It is sampled when a value is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input value offered |
| inReady | output | 1 | Block can take a value this cycle |
| inData | input | 64 | binary64 input value |
| cfgAnchor | input | 12 | Signed weight of the lowest accumulator bit |
| clear | input | 1 | Zero the lanes and flags, and drop the value in flight |
| accLanes | output | 256 | Four 64-bit lane words, lane 0 in the low bits |
| flagInexact | output | 1 | Sticky: bits below the anchor were dropped |
| flagRange | output | 1 | Sticky: a value was above the range and was discarded |
| flagInvalid | output | 1 | Sticky: an infinity or NaN was seen |
| flagLaneOvf | output | 1 | Sticky: a lane overflowed and the host must normalise |

## Verification
The assertions take for granted that `cfgAnchor` stays constant between one clear and the next. A value in flight is always converted with the anchor that was present when it was accepted. The assertions also take for granted that `inData` is a meaningful binary64 value whenever `inValid` is high. The bench changes the anchor only right after a clear. Its random exponents sit in a band around the default anchor, so the stream mixes in-range, inexact and out-of-range values. A long run of near-full lane-0 values is used to force lane overflow on purpose.

// File: rtl/fpacc_pkg.sv
package fpacc_pkg;
  parameter int LANES    = 4;
  parameter int LANE_W   = 64;
  parameter int OVL_W    = 8;
  parameter int ANCHOR_W = 12;
  parameter int SIG_W    = 53;

  localparam int STRIDE  = LANE_W - OVL_W;
  localparam int FIELD_W = LANES * STRIDE;

  typedef struct packed {
    logic convLoad;
    logic accAdd;
    logic clearAll;
  } accStrobe_t;

  typedef logic [LANES-1:0][LANE_W-1:0] laneVec_t;
endpackage

// File: rtl/fpacc_ctrl.sv
module fpacc_ctrl
  import fpacc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       clear,
  output logic       inReady,
  output accStrobe_t strb
);
  logic stageValid;

  always_comb begin
    inReady       = !clear;
    strb.convLoad = inValid && !clear;
    strb.accAdd   = stageValid && !clear;
    strb.clearAll = clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageValid <= 1'b0;
    else       stageValid <= strb.convLoad;
  end

  AST_ACCEPT_REACHES_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (strb.accAdd || clear)) else $error("accept lost"); // R4
endmodule

// File: rtl/fpacc_datapath.sv
module fpacc_datapath
  import fpacc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  accStrobe_t                 strb,
  input  logic [63:0]                inData,
  input  logic signed [ANCHOR_W-1:0] cfgAnchor,
  output laneVec_t                   accQ,
  output logic                       flagInexact,
  output logic                       flagRange,
  output logic                       flagInvalid,
  output logic                       flagLaneOvf
);
  localparam int BIG_W = FIELD_W + 2 * SIG_W;
  localparam int SH_W  = $clog2(BIG_W);

  // ---------------- convert stage ----------------
  logic [10:0]        expField;
  logic [SIG_W-1:0]   sig;
  logic               isSpecial;
  int                 lsbExp;
  int                 pos;
  logic [SH_W-1:0]    shAmt;
  logic [BIG_W-1:0]   big;
  logic [FIELD_W-1:0] field;
  logic               convInexact, convRange;
  laneVec_t           convLane;

  always_comb begin
    expField  = inData[62:52];
    isSpecial = &expField;
    sig       = {(expField != 11'd0), inData[51:0]};
    lsbExp    = (expField == 11'd0) ? -1074 : (int'(expField) - 1075);
    pos       = lsbExp - int'(cfgAnchor);
    field       = '0;
    convInexact = 1'b0;
    convRange   = 1'b0;
    shAmt       = '0;
    big         = '0;
    if (isSpecial) begin
      field = '0;
    end else if (pos + SIG_W <= 0) begin
      convInexact = |sig;
    end else if (pos >= FIELD_W) begin
      convRange = |sig;
    end else begin
      shAmt       = SH_W'(pos + SIG_W);
      big         = BIG_W'(sig) << shAmt;
      field       = big[SIG_W +: FIELD_W];
      convInexact = |big[SIG_W-1:0];
      convRange   = |big[BIG_W-1:SIG_W+FIELD_W];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_split
    logic [LANE_W-1:0] mag;
    assign mag         = {{OVL_W{1'b0}}, field[i*STRIDE +: STRIDE]};
    assign convLane[i] = inData[63] ? (LANE_W'(0) - mag) : mag;
  end

  laneVec_t s1Lane;
  logic     s1Inexact, s1Range, s1Invalid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Lane    <= '0;
      s1Inexact <= 1'b0;
      s1Range   <= 1'b0;
      s1Invalid <= 1'b0;
    end else if (strb.convLoad) begin
      s1Lane    <= convLane;
      s1Inexact <= convInexact;
      s1Range   <= convRange;
      s1Invalid <= isSpecial;
    end
  end

  // ---------------- add stage ----------------
  logic             doAdd;
  laneVec_t         sumLane;
  logic [LANES-1:0] laneOvf;

  assign doAdd = strb.accAdd && !s1Invalid && !s1Range;

  for (genvar i = 0; i < LANES; i++) begin : g_add
    assign sumLane[i] = accQ[i] + s1Lane[i];
    assign laneOvf[i] = (accQ[i][LANE_W-1] == s1Lane[i][LANE_W-1]) &&
                        (sumLane[i][LANE_W-1] != accQ[i][LANE_W-1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ        <= '0;
      flagInexact <= 1'b0;
      flagRange   <= 1'b0;
      flagInvalid <= 1'b0;
      flagLaneOvf <= 1'b0;
    end else if (strb.clearAll) begin
      accQ        <= '0;
      flagInexact <= 1'b0;
      flagRange   <= 1'b0;
      flagInvalid <= 1'b0;
      flagLaneOvf <= 1'b0;
    end else begin
      if (doAdd) begin
        accQ        <= sumLane;
        flagInexact <= flagInexact | s1Inexact;
        flagLaneOvf <= flagLaneOvf | (|laneOvf);
      end
      if (strb.accAdd) begin
        flagRange   <= flagRange | s1Range;
        flagInvalid <= flagInvalid | s1Invalid;
      end
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (accQ == '0) && !flagInexact && !flagRange && !flagInvalid && !flagLaneOvf)
    else $error("clear incomplete"); // R1
  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accAdd && s1Invalid) |=> $stable(accQ) && flagInvalid)
    else $error("invalid changed lanes"); // R9
  AST_RANGE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accAdd && s1Range) |=> $stable(accQ) && flagRange)
    else $error("range value added"); // R7
  AST_LANEOVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagLaneOvf && !strb.clearAll) |=> flagLaneOvf)
    else $error("lane overflow flag lost"); // R10
  AST_INEXACT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagInexact && !strb.clearAll) |=> flagInexact)
    else $error("inexact flag lost"); // R6
endmodule

// File: rtl/fpacc_anchor_top.sv
module fpacc_anchor_top
  import fpacc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [63:0]                  inData,
  input  logic signed [ANCHOR_W-1:0]   cfgAnchor,
  input  logic                         clear,
  output logic [LANES*LANE_W-1:0]      accLanes,
  output logic                         flagInexact,
  output logic                         flagRange,
  output logic                         flagInvalid,
  output logic                         flagLaneOvf
);
  accStrobe_t strb;
  laneVec_t   accQ;

  fpacc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .clear   (clear),
    .inReady (inReady),
    .strb    (strb)
  );

  fpacc_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .inData      (inData),
    .cfgAnchor   (cfgAnchor),
    .accQ        (accQ),
    .flagInexact (flagInexact),
    .flagRange   (flagRange),
    .flagInvalid (flagInvalid),
    .flagLaneOvf (flagLaneOvf)
  );

  assign accLanes = accQ;
endmodule

// File: tb/fpacc_anchor_top_tb.sv
`timescale 1ns/1ps
module fpacc_anchor_top_tb;
  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic               inReady;
  logic [63:0]        inData = '0;
  logic signed [11:0] cfgAnchor = -12'sd76;
  logic               clear = 1'b0;
  logic [255:0]       accLanes;
  logic               flagInexact, flagRange, flagInvalid, flagLaneOvf;

  int nChecks = 0;
  int nFails  = 0;

  logic [63:0] mAcc [4];
  logic        mInx, mRng, mInv, mOvf;
  logic [63:0] stream [300];
  logic [63:0] saved  [4];

  fpacc_anchor_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .cfgAnchor(cfgAnchor), .clear(clear),
    .accLanes(accLanes), .flagInexact(flagInexact), .flagRange(flagRange),
    .flagInvalid(flagInvalid), .flagLaneOvf(flagLaneOvf)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model: bit-by-bit placement of the significand
  task automatic modelAdd(input logic [63:0] v);
    logic [10:0]  e;
    logic [52:0]  m;
    logic [223:0] fld;
    logic [63:0]  w, s;
    int           q, p;
    logic         inx, rng;
    e = v[62:52];
    if (e == 11'h7FF) begin mInv = 1'b1; return; end
    m = {(e != 0), v[51:0]};
    q = (e == 0) ? -1074 : int'(e) - 1075;
    fld = '0; inx = 1'b0; rng = 1'b0;
    for (int j = 0; j < 53; j++) begin
      if (m[j]) begin
        p = q + j - int'(cfgAnchor);
        if (p < 0) inx = 1'b1;
        else if (p > 223) rng = 1'b1;
        else fld[p] = 1'b1;
      end
    end
    if (rng) begin mRng = 1'b1; return; end
    mInx = mInx | inx;
    for (int i = 0; i < 4; i++) begin
      w = {8'h00, fld[i*56 +: 56]};
      if (v[63]) w = 64'd0 - w;
      s = mAcc[i] + w;
      if (mAcc[i][63] == w[63] && s[63] != mAcc[i][63]) mOvf = 1'b1;
      mAcc[i] = s;
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < 4; i++) mAcc[i] = '0;
    mInx = 0; mRng = 0; mInv = 0; mOvf = 0;
  endtask

  task automatic compareAll(input string req);
    for (int i = 0; i < 4; i++) chk(req, accLanes[i*64 +: 64], mAcc[i]);
    chk({req, " flags"}, {60'd0, flagInexact, flagRange, flagInvalid, flagLaneOvf},
        {60'd0, mInx, mRng, mInv, mOvf});
  endtask

  // drive one value at a negedge; it is accepted at the next posedge
  task automatic send(input logic [63:0] v);
    inValid = 1'b1; inData = v;
    modelAdd(v);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic doClear();
    clear = 1'b1;
    #1 chk("R4 ready low in clear", {63'd0, inReady}, 64'd0);
    @(negedge clk);
    clear = 1'b0;
    modelClear();
    compareAll("R1 clear");
  endtask

  function automatic logic [63:0] rndVal();
    logic [63:0] r;
    r[63]    = 1'($urandom % 2);
    r[62:52] = 11'(975 + ($urandom % 200));
    r[51:0]  = {20'($urandom), 32'($urandom)};
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 reset");
    chk("R4 ready idle", {63'd0, inReady}, 64'd1);

    // +1.0: lowest set bit at weight 2^0 -> lane1 bit 20; latency check
    inValid = 1'b1; inData = 64'h3FF0_0000_0000_0000; modelAdd(inData);
    @(negedge clk); inValid = 1'b0;
    chk("R4 not yet visible", accLanes[127:64], 64'd0);
    @(negedge clk);
    chk("R2 one lands in lane1", accLanes[127:64], 64'h0000_0000_0010_0000);
    chk("R4 visible after second edge", accLanes[63:0], 64'd0);

    send(64'hBFF0_0000_0000_0000); settle();            // -1.0
    chk("R3 negative cancels", accLanes[127:64], 64'd0);
    send(64'hC004_0000_0000_0000); settle();            // -2.5
    compareAll("R3 minus two and a half");
    chk("R3 lane1 value", accLanes[127:64], 64'hFFFF_FFFF_FFD8_0000);

    send(64'h0000_0000_0000_0000); send(64'h8000_0000_0000_0000); settle();
    compareAll("R8 zeros no change");

    send(64'h7FF0_0000_0000_0000); send(64'h7FF8_0000_0000_0001); settle();
    compareAll("R9 inf nan");
    chk("R9 flag", {63'd0, flagInvalid}, 64'd1);

    send(64'h7FE0_0000_0000_0000); settle();
    compareAll("R7 above range");
    chk("R7 flag", {63'd0, flagRange}, 64'd1);

    send(64'h39B0_0000_0000_0000); settle();            // 2^-100, below anchor
    compareAll("R6 inexact dropped");
    chk("R6 flag", {63'd0, flagInexact}, 64'd1);

    doClear();
    cfgAnchor = -12'sd1074;
    send(64'h0000_0000_0000_0001); settle();            // smallest subnormal
    chk("R8 R11 subnormal lane0", accLanes[63:0], 64'd1);
    compareAll("R11 low anchor");

    doClear();
    cfgAnchor = -12'sd76;
    for (int k = 0; k < 300; k++) stream[k] = rndVal();
    for (int k = 0; k < 300; k++) begin
      inValid = 1'b1; inData = stream[k]; modelAdd(stream[k]);
      @(negedge clk);
      if (k % 50 == 0) chk("R4 ready while streaming", {63'd0, inReady}, 64'd1);
    end
    inValid = 1'b0; settle();
    compareAll("R2 R3 R6 R7 random forward");
    for (int i = 0; i < 4; i++) saved[i] = accLanes[i*64 +: 64];

    doClear();
    for (int k = 299; k >= 0; k--) begin
      inValid = 1'b1; inData = stream[k]; modelAdd(stream[k]);
      @(negedge clk);
    end
    inValid = 1'b0; settle();
    for (int i = 0; i < 4; i++) chk("R5 reverse order", accLanes[i*64 +: 64], saved[i]);

    // clear in the same cycle a value sits in the convert stage
    inValid = 1'b1; inData = 64'h3FF0_0000_0000_0000;
    @(negedge clk); inValid = 1'b0;
    doClear(); settle();
    compareAll("R1 in-flight dropped");

    // lane overflow: lowest bit at anchor+3 with full fraction, near 2^56 per add
    for (int k = 0; k < 130; k++) begin
      inValid = 1'b1; inData = {1'b0, 11'd1002, 52'hF_FFFF_FFFF_FFFF}; modelAdd(inData);
      @(negedge clk);
    end
    inValid = 1'b0; settle();
    compareAll("R10 lane overflow");
    chk("R10 flag", {63'd0, flagLaneOvf}, 64'd1);

    doClear();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule